// File: doc/BRIEF.md
# Selectable Ring / Twisted-Ring Shift Counter

This block is a shift-register counter whose feedback path can be switched while it runs. The register moves its contents one place toward bit 0 on every rising clock edge. The bit that re-enters at the top stage comes from the bottom stage. In ring mode that bit passes through unchanged, so the loaded pattern circulates and the cycle length depends on the seed. In twisted mode the bit is inverted first, which turns the register into a Johnson counter with twice as many states as it has stages.

A synchronous load places any seed pattern into the register, so software-free control logic can pick a one-hot, one-cold or arbitrary ring pattern. An asynchronous active-low clear forces all zeros, which is the usual starting point for twisted mode. The stage count is a parameter and defaults to four.

Top module: `twist_ring_counter`

## Requirements
- R1: While clr_n is low the state is all zeros, immediately and regardless of clock, load or mode; clear outranks a load present at the same edge.
- R2: When seed_ld is 1 at a rising edge (clear inactive), the state becomes seed_val on that edge whatever the value of twist.
- R3: With seed_ld 0 and twist 0 (ring), each edge gives next = {state[0], state[STAGES-1:1]}: bit 0 wraps unchanged into the top bit.
- R4: In ring mode a seed of 1000 (bit 3 set) steps 0100, 0010, 0001 and returns to 1000 on the fourth edge.
- R5: In ring mode a seed of 1010 alternates with 0101 and repeats every two edges.
- R6: In ring mode a seed of 0111 moves a single zero: 1011, 1101, 1110, then 0111 again.
- R7: With seed_ld 0 and twist 1 (twisted), each edge gives next = {~state[0], state[STAGES-1:1]}.
- R8: In twisted mode, starting from all zeros, the state visits 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001 and is back at 0000 after eight edges (2 x STAGES states).
- R9: Changing twist between edges leaves the state unchanged until the next rising edge, where the new mode applies.
- R10: In ring mode the number of ones in the state never changes from one edge to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear to all zeros, active low |
| seed_ld | input | 1 | Synchronous load of seed_val, above shifting in priority |
| seed_val | input | STAGES | Pattern to load |
| twist | input | 1 | Feedback select: 0 ring, 1 inverted (Johnson) |
| state | output | STAGES | Current register contents |

## Verification
The bench targets the wrap point, where a design that took feedback from the wrong end or shifted the wrong way would produce a mirrored sequence, and the inversion, where a missing or misplaced inverter makes twisted mode behave as a ring stuck at 0000. It loads the one-hot, one-cold and alternating seeds to catch a load that drops bits or yields to shifting, and clears with a load pending to show that clear wins. Mode toggles between edges expose any design that reacts to twist combinationally rather than at the edge.

// File: rtl/twist_ring_pkg.sv
package twist_ring_pkg;

   typedef enum logic {
      FB_RING  = 1'b0,
      FB_TWIST = 1'b1
   } fb_mode_e;

   typedef enum logic [1:0] {
      ACT_SHIFT = 2'd0,
      ACT_LOAD  = 2'd1
   } stage_act_e;

endpackage

// File: rtl/twist_ring_feedback.sv
module twist_ring_feedback
   import twist_ring_pkg::*;
(
   input  fb_mode_e mode,
   input  logic     tail_bit,
   output logic     head_bit
);

   always_comb begin
      unique case (mode)
         FB_TWIST: head_bit = ~tail_bit;
         default:  head_bit = tail_bit;
      endcase
   end

endmodule

// File: rtl/twist_ring_stage.sv
module twist_ring_stage
   import twist_ring_pkg::*;
(
   input  logic       clk,
   input  logic       clr_n,
   input  stage_act_e act,
   input  logic       load_bit,
   input  logic       shift_bit,
   output logic       q
);

   logic d_next;

   always_comb begin
      unique case (act)
         ACT_LOAD: d_next = load_bit;
         default:  d_next = shift_bit;
      endcase
   end

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) q <= 1'b0;
      else        q <= d_next;
   end

endmodule

// File: rtl/twist_ring_counter.sv
module twist_ring_counter
   import twist_ring_pkg::*;
#(
   parameter int STAGES = 4
) (
   input  logic              clk,
   input  logic              clr_n,
   input  logic              seed_ld,
   input  logic [STAGES-1:0] seed_val,
   input  logic              twist,
   output logic [STAGES-1:0] state
);

   localparam int TOP = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("twist_ring_counter needs at least two stages");
   end

   fb_mode_e          mode;
   stage_act_e        act;
   logic              head_bit;
   logic [STAGES-1:0] shift_in;

   assign mode = fb_mode_e'(twist);
   assign act  = seed_ld ? ACT_LOAD : ACT_SHIFT;

   twist_ring_feedback u_fb (
      .mode     (mode),
      .tail_bit (state[0]),
      .head_bit (head_bit)
   );

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == TOP) begin : g_head
         assign shift_in[i] = head_bit;
      end else begin : g_body
         assign shift_in[i] = state[i+1];
      end

      twist_ring_stage u_stage (
         .clk       (clk),
         .clr_n     (clr_n),
         .act       (act),
         .load_bit  (seed_val[i]),
         .shift_bit (shift_in[i]),
         .q         (state[i])
      );
   end

endmodule

// File: rtl/twist_ring_counter_chk.sv
module twist_ring_counter_chk #(
   parameter int STAGES = 4
) (
   input logic              clk,
   input logic              clr_n,
   input logic              seed_ld,
   input logic [STAGES-1:0] seed_val,
   input logic              twist,
   input logic [STAGES-1:0] state
);

   localparam logic [STAGES-1:0] HEAD_ONE = {1'b1, {(STAGES-1){1'b0}}};

   AST_CLEAR_ZERO: assert property (@(posedge clk)
      !clr_n |-> state == '0); // R1

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!clr_n)
      seed_ld |=> state == $past(seed_val)); // R2

   AST_RING_STEP: assert property (@(posedge clk) disable iff (!clr_n)
      (!seed_ld && !twist) |=> state == {$past(state[0]), $past(state[STAGES-1:1])}); // R3

   AST_TWIST_STEP: assert property (@(posedge clk) disable iff (!clr_n)
      (!seed_ld && twist) |=> state == {~$past(state[0]), $past(state[STAGES-1:1])}); // R7

   AST_TWIST_LEAVE_ZERO: assert property (@(posedge clk) disable iff (!clr_n)
      (!seed_ld && twist && state == '0) |=> state == HEAD_ONE); // R8

   AST_RING_ONES: assert property (@(posedge clk) disable iff (!clr_n)
      (!seed_ld && !twist) |=> $countones(state) == $countones($past(state))); // R10

endmodule

bind twist_ring_counter twist_ring_counter_chk #(.STAGES(STAGES)) u_chk (
   .clk      (clk),
   .clr_n    (clr_n),
   .seed_ld  (seed_ld),
   .seed_val (seed_val),
   .twist    (twist),
   .state    (state)
);

// File: tb/twist_ring_counter_bench.sv
`timescale 1ns/100ps
module twist_ring_counter_bench;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         clr_n = 1'b1;
   logic         seed_ld = 1'b0;
   logic [N-1:0] seed_val = '0;
   logic         twist = 1'b0;
   logic [N-1:0] state;

   int checks = 0;
   int failures = 0;
   logic [N-1:0] exp_state = '0;
   bit done = 0;

   always #2 clk = ~clk;

   twist_ring_counter #(.STAGES(N)) u_twist_ring_counter (
      .clk(clk), .clr_n(clr_n), .seed_ld(seed_ld),
      .seed_val(seed_val), .twist(twist), .state(state)
   );

   function automatic logic [N-1:0] model_next(logic [N-1:0] cur, logic ld,
                                               logic [N-1:0] val, logic tw);
      if (ld) return val;
      if (tw) return {~cur[0], cur[N-1:1]};
      return {cur[0], cur[N-1:1]};
   endfunction

   task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic step(string req, logic ld, logic [N-1:0] val, logic tw);
      @(negedge clk);
      seed_ld = ld; seed_val = val; twist = tw;
      @(posedge clk);
      #1;
      exp_state = model_next(exp_state, ld, val, tw);
      chk(req, state, exp_state);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         finish_run();
      end
   end

   initial begin
      logic [N-1:0] seq8 [8];
      void'($urandom(32'd20240611));
      seq8[0] = 4'b0000; seq8[1] = 4'b1000; seq8[2] = 4'b1100; seq8[3] = 4'b1110;
      seq8[4] = 4'b1111; seq8[5] = 4'b0111; seq8[6] = 4'b0011; seq8[7] = 4'b0001;

      // R1: reset state
      #1 clr_n = 1'b0;
      #1; exp_state = '0;
      chk("R1 reset", state, '0);
      @(negedge clk); clr_n = 1'b1;

      // R4: one-hot ring
      step("R2 load 1000", 1'b1, 4'b1000, 1'b0);
      step("R4 ring", 1'b0, '0, 1'b0); chk("R4 0100", state, 4'b0100);
      step("R4 ring", 1'b0, '0, 1'b0); chk("R4 0010", state, 4'b0010);
      step("R4 ring", 1'b0, '0, 1'b0); chk("R4 0001", state, 4'b0001);
      step("R4 ring", 1'b0, '0, 1'b0); chk("R4 wrap", state, 4'b1000);

      // R5: alternating seed
      step("R2 load 1010", 1'b1, 4'b1010, 1'b0);
      step("R5 ring", 1'b0, '0, 1'b0); chk("R5 0101", state, 4'b0101);
      step("R5 ring", 1'b0, '0, 1'b0); chk("R5 1010", state, 4'b1010);

      // R6: one-cold ring
      step("R2 load 0111", 1'b1, 4'b0111, 1'b0);
      step("R6 ring", 1'b0, '0, 1'b0); chk("R6 1011", state, 4'b1011);
      step("R6 ring", 1'b0, '0, 1'b0); chk("R6 1101", state, 4'b1101);
      step("R6 ring", 1'b0, '0, 1'b0); chk("R6 1110", state, 4'b1110);
      step("R6 ring", 1'b0, '0, 1'b0); chk("R6 0111", state, 4'b0111);

      // R1: clear mid-cycle with a load pending; clear wins
      @(posedge clk); #1;
      seed_ld = 1'b1; seed_val = 4'b1011;
      clr_n = 1'b0;
      #0.5; exp_state = '0;
      chk("R1 async clear", state, '0);
      @(posedge clk); #1;
      chk("R1 clear over load", state, '0);
      @(negedge clk); clr_n = 1'b1; seed_ld = 1'b0;

      // R8: twisted sequence from zero, two full laps
      for (int k = 1; k <= 16; k++) begin
         step("R7 twist", 1'b0, '0, 1'b1);
         chk("R8 johnson seq", state, seq8[k % 8]);
      end

      // R2: load ignores mode
      step("R2 load in twist", 1'b1, 4'b0110, 1'b1);
      chk("R2 seed 0110", state, 4'b0110);

      // R9: mode change between edges does not touch state
      @(negedge clk);
      seed_ld = 1'b0; twist = 1'b0;
      #0.5; chk("R9 hold after ->ring", state, exp_state);
      twist = 1'b1;
      #0.5; chk("R9 hold after ->twist", state, exp_state);
      @(posedge clk); #1;
      exp_state = model_next(exp_state, 1'b0, '0, 1'b1);
      chk("R9 new mode at edge", state, exp_state);

      // R10: ring keeps ones count
      step("R2 load 1101", 1'b1, 4'b1101, 1'b0);
      for (int k = 0; k < 6; k++) begin
         step("R3 ring", 1'b0, '0, 1'b0);
         checks++;
         if ($countones(state) != 3) begin
            failures++;
            $display("FAIL R10 ones actual=%0d expected=3", $countones(state));
         end
      end

      // Random mix, R3 / R7 / R2
      for (int k = 0; k < 400; k++) begin
         logic ld;
         logic tw;
         logic [N-1:0] v;
         ld = ($urandom % 8) == 0;
         tw = $urandom % 2;
         v  = N'($urandom);
         step(ld ? "R2 rand" : (tw ? "R7 rand" : "R3 rand"), ld, v, tw);
      end

      done = 1;
      finish_run();
   end

endmodule